// File: doc/BRIEF.md
# Watchdog Timer with Frequency-Select Fallback

This block guards the frequency programming of a clock generator. Software programs a normal frequency-select code, a fallback code, a timer unit, an interval count and a control byte through a simple register write port. Once the timer is enabled, it must be serviced. A kick pulse or any write to a configuration register restarts it. If it is left unserviced for unit length × interval ticks of the millisecond time base, the block emits a one-cycle `wd_reset` pulse and switches its frequency-select output to a fallback code.

The fallback code comes either from the programmed fallback register or from the external jumper inputs. It is captured at the moment of expiry and held until software clears the enable bit. On the same event, a configuration bit decides whether the linear-programming byte is cleared or kept.

The unit lengths are parameters. Their defaults of 250, 500, 1000 and 4000 ticks match 250 ms, 500 ms, 1 s and 4 s with a 1 ms tick, so a bench can shrink them.

The write port is a plain single-cycle strobe. It is always accepted and has no back-pressure. Kick and tick are single-cycle level-sampled strobes.

Top module: `wdog_fs_fallback`

## Requirements
- R1: After reset, `fs_out`, `lin_prog`, `wd_reset` and `fallback_active` are 0, and every register is 0 (timer disabled).
- R2: With the timer running, `wd_reset` goes high for exactly one cycle. It rises in the cycle after the tick that completes U[sel] × interval ticks since the last reload, and not earlier. The timer register sits at address 3, with sel in bits [7:6] and interval in bits [5:0]. U[0..3] are the parameters U0..U3.
- R3: A kick, or a write to any of addresses 0 to 4, restarts the count from zero. A write to addresses 5 to 7 changes nothing and does not restart the count.
- R4: An interval of 0 never expires.
- R5: Enable is bit 0 of the control register at address 4. While it is 0 no expiry occurs, and writing it to 0 discards any progress immediately.
- R6: `fallback_active` rises together with `wd_reset` and stays set through kicks, ticks, other writes and a control write with enable=1. Only a control write with bit 0 = 0 clears it. No further `wd_reset` occurs while it is set.
- R7: While the fallback is active, `fs_out` holds the code captured at expiry. That code is fallback register (address 2) bits [3:0] if control bit 1 is 1, and `jumper_fs` otherwise. Later changes to either source do not alter it.
- R8: While the fallback is not active, `fs_out` equals bits [3:0] of the frequency register at address 0, starting the cycle after the write.
- R9: At expiry, `lin_prog` (the register at address 1) is cleared to 0 if bit 7 of the fallback register is 0, and kept if that bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| kick | input | 1 | Watchdog service pulse |
| tick_ms | input | 1 | Time-base tick, one cycle per tick |
| jumper_fs | input | 4 | Hardware jumper frequency code |
| fs_out | output | 4 | Effective frequency-select code |
| wd_reset | output | 1 | One-cycle watchdog reset event |
| fallback_active | output | 1 | Sticky fallback indicator |
| lin_prog | output | 8 | Linear-programming byte |

## Verification
The assertions assume that `wr_en`, `kick` and `tick_ms` are sampled only at rising edges and that no input is X after reset. They also assume that a write restarts the count in the same cycle it lands, so an expiry and a write never share a cycle. The bench drives every strobe for exactly one cycle on the falling edge, so the design sees clean one-cycle pulses. The bench sweeps all four units against intervals 1 to 6 with small unit lengths, alternating the fallback source and the keep bit. It computes the expiry tick count as a product.

// File: rtl/wdf_pkg.sv
package wdf_pkg;
  localparam int FS_W   = 4;
  localparam int LIN_W  = 8;
  localparam int INTV_W = 6;
  localparam int SEL_W  = 2;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    A_FREQ = 3'd0,
    A_LIN  = 3'd1,
    A_FB   = 3'd2,
    A_TMR  = 3'd3,
    A_CTL  = 3'd4
  } reg_addr_e;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/wdf_regs.sv
module wdf_regs
  import wdf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              expire,
  output logic [FS_W-1:0]   freq_q,
  output logic [LIN_W-1:0]  lin_q,
  output logic [FS_W-1:0]   fb_code_q,
  output logic [SEL_W-1:0]  unit_q,
  output logic [INTV_W-1:0] intv_q,
  output logic              en_q,
  output logic              src_q,
  output logic              cfg_write,
  output logic              fb_clear
);
  logic keep_q;

  assign cfg_write = wr_en && (wr_addr <= A_CTL);
  assign fb_clear  = wr_en && (wr_addr == A_CTL) && !wr_data[0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      freq_q    <= '0;
      lin_q     <= '0;
      fb_code_q <= '0;
      keep_q    <= 1'b0;
      unit_q    <= '0;
      intv_q    <= '0;
      en_q      <= 1'b0;
      src_q     <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_FREQ: freq_q <= wr_data[FS_W-1:0];
          A_LIN:  lin_q  <= wr_data;
          A_FB: begin
            fb_code_q <= wr_data[FS_W-1:0];
            keep_q    <= wr_data[7];
          end
          A_TMR: begin
            unit_q <= wr_data[7:6];
            intv_q <= wr_data[INTV_W-1:0];
          end
          A_CTL: begin
            en_q  <= wr_data[0];
            src_q <= wr_data[1];
          end
          default: ;
        endcase
      end
      if (expire && !keep_q) lin_q <= '0;
    end
  end
endmodule

// File: rtl/wdf_timer.sv
module wdf_timer
  import wdf_pkg::*;
#(
  parameter int U0 = 250,
  parameter int U1 = 500,
  parameter int U2 = 1000,
  parameter int U3 = 4000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reload,
  input  logic              en,
  input  logic              halt,
  input  logic [SEL_W-1:0]  unit_sel,
  input  logic [INTV_W-1:0] intv,
  output logic              expire,
  output logic              wd_reset
);
  localparam int UMAX = max4(U0, U1, U2, U3);
  localparam int UW   = $clog2(UMAX + 1);
  localparam int ULEN [4] = '{U0, U1, U2, U3};

  logic [UW-1:0]     ucnt;
  logic [INTV_W-1:0] ecnt;
  logic [3:0]        last_vec;
  logic              unit_last;
  logic              run;

  for (genvar g = 0; g < 4; g++) begin : g_last
    assign last_vec[g] = (ucnt == UW'(ULEN[g] - 1));
  end

  assign unit_last = last_vec[unit_sel];
  assign run       = en && (intv != '0) && !halt && !reload;
  assign expire    = run && tick && unit_last && (ecnt == intv - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ucnt     <= '0;
      ecnt     <= '0;
      wd_reset <= 1'b0;
    end else begin
      wd_reset <= expire;
      if (reload || !en) begin
        ucnt <= '0;
        ecnt <= '0;
      end else if (run && tick) begin
        if (unit_last) begin
          ucnt <= '0;
          ecnt <= ecnt + 1'b1;
        end else begin
          ucnt <= ucnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/wdf_fsmux.sv
module wdf_fsmux
  import wdf_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            expire,
  input  logic            fb_clear,
  input  logic            src_prog,
  input  logic [FS_W-1:0] fb_code,
  input  logic [FS_W-1:0] jumper,
  input  logic [FS_W-1:0] freq,
  output logic            active,
  output logic [FS_W-1:0] fs_out
);
  logic [FS_W-1:0] held;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      held   <= '0;
    end else if (fb_clear) begin
      active <= 1'b0;
    end else if (expire) begin
      active <= 1'b1;
      held   <= src_prog ? fb_code : jumper;
    end
  end

  assign fs_out = active ? held : freq;
endmodule

// File: rtl/wdog_fs_fallback.sv
module wdog_fs_fallback
  import wdf_pkg::*;
#(
  parameter int U0 = 250,
  parameter int U1 = 500,
  parameter int U2 = 1000,
  parameter int U3 = 4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_addr,
  input  logic [7:0]  wr_data,
  input  logic        kick,
  input  logic        tick_ms,
  input  logic [3:0]  jumper_fs,
  output logic [3:0]  fs_out,
  output logic        wd_reset,
  output logic        fallback_active,
  output logic [7:0]  lin_prog
);
  logic [FS_W-1:0]   freq_q;
  logic [FS_W-1:0]   fb_code_q;
  logic [SEL_W-1:0]  unit_q;
  logic [INTV_W-1:0] intv_q;
  logic              en_q;
  logic              src_q;
  logic              cfg_write;
  logic              fb_clear;
  logic              expire;

  wdf_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .expire    (expire),
    .freq_q    (freq_q),
    .lin_q     (lin_prog),
    .fb_code_q (fb_code_q),
    .unit_q    (unit_q),
    .intv_q    (intv_q),
    .en_q      (en_q),
    .src_q     (src_q),
    .cfg_write (cfg_write),
    .fb_clear  (fb_clear)
  );

  wdf_timer #(.U0(U0), .U1(U1), .U2(U2), .U3(U3)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick_ms),
    .reload   (cfg_write || kick),
    .en       (en_q),
    .halt     (fallback_active),
    .unit_sel (unit_q),
    .intv     (intv_q),
    .expire   (expire),
    .wd_reset (wd_reset)
  );

  wdf_fsmux u_fsmux (
    .clk      (clk),
    .rst_n    (rst_n),
    .expire   (expire),
    .fb_clear (fb_clear),
    .src_prog (src_q),
    .fb_code  (fb_code_q),
    .jumper   (jumper_fs),
    .freq     (freq_q),
    .active   (fallback_active),
    .fs_out   (fs_out)
  );
endmodule

// File: rtl/wdf_chk.sv
module wdf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [2:0] wr_addr,
  input logic [7:0] wr_data,
  input logic       kick,
  input logic [3:0] fs_out,
  input logic       wd_reset,
  input logic       fallback_active,
  input logic [7:0] lin_prog,
  input logic       en,
  input logic       keep
);
  logic ctl_off_wr;
  assign ctl_off_wr = wr_en && (wr_addr == 3'd4) && !wr_data[0];

  // R2
  pulse_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |=> !wd_reset);

  // R6
  pulse_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset |-> fallback_active);

  // R6
  flag_rise_with_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fallback_active) |-> wd_reset);

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_active && !ctl_off_wr) |=> fallback_active);

  // R3
  kick_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> !wd_reset);

  // R5
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !wd_reset);

  // R7
  fallback_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fallback_active && !ctl_off_wr) |=> $stable(fs_out));

  // R9
  lin_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_reset && !keep) |-> (lin_prog == 8'd0));
endmodule

bind wdog_fs_fallback wdf_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_en           (wr_en),
  .wr_addr         (wr_addr),
  .wr_data         (wr_data),
  .kick            (kick),
  .fs_out          (fs_out),
  .wd_reset        (wd_reset),
  .fallback_active (fallback_active),
  .lin_prog        (lin_prog),
  .en              (en_q),
  .keep            (u_regs.keep_q)
);

// File: tb/sim_wdog_fs_fallback.sv
module sim_wdog_fs_fallback;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int U0 = 2, U1 = 3, U2 = 5, U3 = 7;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       kick = 1'b0;
  logic       tick_ms = 1'b0;
  logic [3:0] jumper_fs = '0;
  logic [3:0] fs_out;
  logic       wd_reset;
  logic       fallback_active;
  logic [7:0] lin_prog;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  wdog_fs_fallback #(.U0(U0), .U1(U1), .U2(U2), .U3(U3)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .kick(kick), .tick_ms(tick_ms), .jumper_fs(jumper_fs), .fs_out(fs_out),
    .wd_reset(wd_reset), .fallback_active(fallback_active), .lin_prog(lin_prog)
  );

  function automatic int ulen(input int s);
    case (s)
      0: return U0;
      1: return U1;
      2: return U2;
      default: return U3;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tick_ms = 1'b1;
      @(negedge clk); tick_ms = 1'b0;
    end
  endtask

  task automatic do_kick();
    @(negedge clk); kick = 1'b1;
    @(negedge clk); kick = 1'b0;
  endtask

  task automatic ticks_quiet(input string req, input int n);
    for (int k = 0; k < n; k++) begin
      do_tick(1);
      chk(req, int'(wd_reset), 0);
    end
  endtask

  task automatic run_case(input int u, input int iv, input int src, input int keep);
    int fr, fb, jp, ln, n;
    fr = (u * 6 + iv) & 15;
    fb = (~fr) & 15;
    jp = fr ^ 5;
    ln = 8'hA5 ^ (u * 16 + iv);
    n  = ulen(u) * iv;
    wr(4, 0);
    wr(0, fr);
    wr(1, ln);
    wr(2, keep * 128 + fb);
    wr(3, u * 64 + iv);
    jumper_fs = 4'(jp);
    chk("R8 normal code", int'(fs_out), fr);
    chk("R6 flag clear", int'(fallback_active), 0);
    wr(4, src * 2 + 1);
    ticks_quiet("R2 early", n - 1);
    chk("R6 no flag early", int'(fallback_active), 0);
    do_tick(1);
    chk("R2 pulse", int'(wd_reset), 1);
    chk("R6 flag set", int'(fallback_active), 1);
    chk("R7 fallback code", int'(fs_out), src ? fb : jp);
    chk("R9 lin byte", int'(lin_prog), keep ? ln : 0);
    @(negedge clk);
    chk("R2 one cycle", int'(wd_reset), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual 0 expected 1 (run finished)");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 fs_out", int'(fs_out), 0);
    chk("R1 lin_prog", int'(lin_prog), 0);
    chk("R1 wd_reset", int'(wd_reset), 0);
    chk("R1 fallback", int'(fallback_active), 0);
    ticks_quiet("R1 disabled", 20);

    // R2 R7 R9 sweep
    for (int u = 0; u < 4; u++)
      for (int iv = 1; iv <= 6; iv++)
        run_case(u, iv, (u + iv) & 1, iv & 1);

    // R4 interval zero
    wr(4, 0); wr(3, 0); wr(4, 1);
    ticks_quiet("R4 zero interval", 60);
    chk("R4 no flag", int'(fallback_active), 0);

    // R3 kick restarts; unit 1, interval 4 -> 12 ticks
    wr(4, 0); wr(3, 64 + 4); wr(4, 1);
    ticks_quiet("R3 before kick", 11);
    do_kick();
    ticks_quiet("R3 after kick", 11);
    do_tick(1);
    chk("R3 expiry after kick", int'(wd_reset), 1);

    // R3 write to address 6 ignored
    wr(0, 3); wr(4, 0); wr(3, 64 + 4); wr(4, 1);
    ticks_quiet("R3 pre", 6);
    wr(6, 8'hFF);
    chk("R3 addr6 fs", int'(fs_out), 3);
    ticks_quiet("R3 post", 5);
    do_tick(1);
    chk("R3 addr6 no reload", int'(wd_reset), 1);

    // R3 write to address 0 restarts
    wr(4, 0); wr(3, 64 + 4); wr(4, 1);
    ticks_quiet("R3 pre wr0", 8);
    wr(0, 9);
    ticks_quiet("R3 post wr0", 11);
    do_tick(1);
    chk("R3 wr0 reload", int'(wd_reset), 1);

    // R5 disable discards progress
    wr(4, 0); wr(3, 64 + 4); wr(4, 1);
    ticks_quiet("R5 pre", 11);
    wr(4, 0);
    ticks_quiet("R5 disabled", 30);
    wr(4, 1);
    ticks_quiet("R5 re-enabled", 11);
    do_tick(1);
    chk("R5 fresh count", int'(wd_reset), 1);

    // R6 R7 sticky and held; current fallback via jumper source (ctl=1)
    jumper_fs = 4'd6;
    wr(4, 0); wr(0, 2); wr(2, 128 + 12); wr(3, 1); wr(4, 1);
    do_tick(1); do_tick(1);
    chk("R6 expiry", int'(fallback_active), 1);
    chk("R7 jumper code", int'(fs_out), 6);
    jumper_fs = 4'd1;
    wr(2, 128 + 5);
    wr(0, 7);
    do_kick();
    wr(4, 3);
    ticks_quiet("R6 no second pulse", 20);
    chk("R6 still active", int'(fallback_active), 1);
    chk("R7 held code", int'(fs_out), 6);
    wr(4, 0);
    chk("R6 cleared", int'(fallback_active), 0);
    chk("R8 back to normal", int'(fs_out), 7);
    wr(0, 11);
    chk("R8 follows write", int'(fs_out), 11);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule